// File: doc/BRIEF.md
# Vertex/Element Operand Address Counter

This block produces operand addresses for a vector-oriented geometry engine. Memory holds every vector (a vertex, a matrix row) in a block of four words that starts on a four-word boundary. The counter is therefore split into two fields. The upper field selects the vector block. The lower field selects the component inside that block.

A small opcode from the microcode chooses one of three kinds of step. The first is a full-width step, where the two fields behave as one counter and a carry or borrow passes from the component field into the block field. The second is a component-only step, which wraps modulo the block size and leaves the block field alone. The third is a block-only step, which moves the address by one whole block. Because the carry into the block field can be suppressed this way, no separate address adder is needed.

A parallel load from the shared internal bus takes priority over any step. A registered readback places the counter value on the bus one cycle after a drive request. Together these let the counter exchange values with its neighbours and with loop counters.

Top module: `oac_counter`

## Requirements
- R1: Reset (rst_n low) clears the address to zero, drives bus_dout to zero and holds bus_oe low.
- R2: op code 1 (full increment) adds one to the whole 18-bit address; the element field carries into the vertex field, and 0x3FFFF wraps to 0x00000.
- R3: op code 2 (full decrement) subtracts one from the whole address; the element field borrows from the vertex field, and 0x00000 wraps to 0x3FFFF.
- R4: op code 3 (element increment) adds one to the low 2-bit element field modulo 4 and leaves the upper 16-bit vertex field unchanged.
- R5: op code 4 (element decrement) subtracts one from the element field modulo 4 and leaves the vertex field unchanged.
- R6: op code 5 (vertex increment) adds 4 to the address: the vertex field goes up by one modulo 2^16 and the element field is unchanged.
- R7: op code 6 (vertex decrement) subtracts 4 from the address: the vertex field goes down by one modulo 2^16 and the element field is unchanged.
- R8: When ld_en is high, the address takes bus_din at the clock edge, whatever op holds.
- R9: op codes 0 and 7 with ld_en low leave the address unchanged.
- R10: When rd_en is high at a clock edge, bus_dout shows the address as it was before that edge and bus_oe is high for the following cycle; otherwise bus_oe is low and bus_dout is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Step opcode (0 hold, 1 inc, 2 dec, 3 elem inc, 4 elem dec, 5 vtx inc, 6 vtx dec, 7 hold) |
| ld_en | input | 1 | Parallel load from the bus, overrides op |
| bus_din | input | 18 | Load value from the internal bus |
| rd_en | input | 1 | Request to drive the counter value onto the bus |
| addr | output | 18 | Operand address, vertex field in [17:2], element field in [1:0] |
| bus_dout | output | 18 | Registered readback value, zero when not driving |
| bus_oe | output | 1 | Readback drive enable for the bus fabric |

## Verification
The bench builds the block with the default 16-bit vertex field and 2-bit element field, which gives the 18-bit address. With that width a parallel load can put the counter right beside the all-ones and all-zeros boundaries. This brings the full-width wrap, the vertex-only wrap and the carry from element 3 into the vertex field within a few cycles. It also checks that a load beats a simultaneous step, and that the readback carries the value from before the edge even while the counter steps in that same cycle.

// File: rtl/oac_pkg.sv
package oac_pkg;
   typedef enum logic [2:0] {
      OAC_HOLD  = 3'd0,
      OAC_INC   = 3'd1,
      OAC_DEC   = 3'd2,
      OAC_EINC  = 3'd3,
      OAC_EDEC  = 3'd4,
      OAC_VINC  = 3'd5,
      OAC_VDEC  = 3'd6,
      OAC_HOLD2 = 3'd7
   } oac_op_t;
endpackage

// File: rtl/oac_elem_field.sv
module oac_elem_field #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         up,
   input  logic         dn,
   output logic [W-1:0] q,
   output logic         cy,
   output logic         bw
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= ld_val;
      else if (up) q <= q + ONE;
      else if (dn) q <= q - ONE;
   end

   assign cy = up && (&q);
   assign bw = dn && !(|q);

   AST_ELEM_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && dn)); // R4
endmodule

// File: rtl/oac_vtx_field.sv
module oac_vtx_field #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         up,
   input  logic         dn,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= ld_val;
      else if (up) q <= q + ONE;
      else if (dn) q <= q - ONE;
   end

   AST_VTX_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && dn)); // R6
endmodule

// File: rtl/oac_counter.sv
module oac_counter
   import oac_pkg::*;
#(
   parameter int VTX_W  = 16,
   parameter int ELEM_W = 2,
   localparam int ADDR_W = VTX_W + ELEM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] bus_din,
   input  logic              rd_en,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] bus_dout,
   output logic              bus_oe
);
   generate
      if (VTX_W < 1)  begin : g_bad_vtx  $error("VTX_W must be at least 1");  end
      if (ELEM_W < 1) begin : g_bad_elem $error("ELEM_W must be at least 1"); end
   endgenerate

   oac_op_t          op_q;
   logic             e_up, e_dn, e_cy, e_bw, v_up, v_dn;
   logic [ELEM_W-1:0] elem;
   logic [VTX_W-1:0]  vtx;
   logic [ADDR_W-1:0] rb_q;
   logic              rb_v;

   always_comb begin
      op_q = oac_op_t'(op);
      e_up = !ld_en && (op_q == OAC_INC || op_q == OAC_EINC);
      e_dn = !ld_en && (op_q == OAC_DEC || op_q == OAC_EDEC);
      v_up = !ld_en && ((op_q == OAC_VINC) || (op_q == OAC_INC && e_cy));
      v_dn = !ld_en && ((op_q == OAC_VDEC) || (op_q == OAC_DEC && e_bw));
   end

   oac_elem_field #(.W(ELEM_W)) u_elem (
      .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(bus_din[ELEM_W-1:0]),
      .up(e_up), .dn(e_dn), .q(elem), .cy(e_cy), .bw(e_bw));

   oac_vtx_field #(.W(VTX_W)) u_vtx (
      .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(bus_din[ADDR_W-1:ELEM_W]),
      .up(v_up), .dn(v_dn), .q(vtx));

   assign addr = {vtx, elem};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rb_q <= '0;
         rb_v <= 1'b0;
      end else begin
         rb_v <= rd_en;
         rb_q <= rd_en ? addr : '0;
      end
   end

   assign bus_dout = rb_v ? rb_q : '0;
   assign bus_oe   = rb_v;

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> addr == $past(bus_din)); // R8
   AST_FULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && op == 3'd1) |=> addr == $past(addr) + ADDR_W'(1)); // R2
   AST_FULL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && op == 3'd2) |=> addr == $past(addr) - ADDR_W'(1)); // R3
   AST_ELEM_KEEPS_VTX: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && (op == 3'd3 || op == 3'd4)) |=> $stable(vtx)); // R5
   AST_VTX_KEEPS_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && (op == 3'd5 || op == 3'd6)) |=> $stable(elem)); // R7
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && (op == 3'd0 || op == 3'd7)) |=> $stable(addr)); // R9
   AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (bus_oe && bus_dout == $past(addr))); // R10
   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> bus_dout == '0); // R10
endmodule

// File: tb/sim_oac_counter.sv
module sim_oac_counter;
   localparam int AW = 18;
   localparam int NV = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op = 3'd0;
   logic          ld_en = 1'b0;
   logic [AW-1:0] bus_din = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr, bus_dout;
   logic          bus_oe;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   oac_counter u0 (.clk(clk), .rst_n(rst_n), .op(op), .ld_en(ld_en),
      .bus_din(bus_din), .rd_en(rd_en), .addr(addr), .bus_dout(bus_dout),
      .bus_oe(bus_oe));

   // entry: {req[3:0], ld, din[17:0], op[2:0], expected addr[17:0]}
   localparam logic [43:0] VEC [NV] = '{
      {4'd8, 1'b1, 18'h3FFFE, 3'd1, 18'h3FFFE},
      {4'd2, 1'b0, 18'h00000, 3'd1, 18'h3FFFF},
      {4'd2, 1'b0, 18'h00000, 3'd1, 18'h00000},
      {4'd3, 1'b0, 18'h00000, 3'd2, 18'h3FFFF},
      {4'd4, 1'b0, 18'h00000, 3'd3, 18'h3FFFC},
      {4'd5, 1'b0, 18'h00000, 3'd4, 18'h3FFFF},
      {4'd6, 1'b0, 18'h00000, 3'd5, 18'h00003},
      {4'd7, 1'b0, 18'h00000, 3'd6, 18'h3FFFF},
      {4'd8, 1'b1, 18'h01235, 3'd0, 18'h01235},
      {4'd2, 1'b0, 18'h00000, 3'd1, 18'h01236},
      {4'd2, 1'b0, 18'h00000, 3'd1, 18'h01237},
      {4'd2, 1'b0, 18'h00000, 3'd1, 18'h01238},
      {4'd3, 1'b0, 18'h00000, 3'd2, 18'h01237},
      {4'd4, 1'b0, 18'h00000, 3'd3, 18'h01234},
      {4'd5, 1'b0, 18'h00000, 3'd4, 18'h01237},
      {4'd6, 1'b0, 18'h00000, 3'd5, 18'h0123B},
      {4'd7, 1'b0, 18'h00000, 3'd6, 18'h01237},
      {4'd9, 1'b0, 18'h00000, 3'd7, 18'h01237},
      {4'd9, 1'b0, 18'h00000, 3'd0, 18'h01237},
      {4'd8, 1'b1, 18'h00000, 3'd6, 18'h00000},
      {4'd7, 1'b0, 18'h00000, 3'd6, 18'h3FFFC},
      {4'd5, 1'b0, 18'h00000, 3'd4, 18'h3FFFF}
   };

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
      end
   endtask

   task automatic step(input logic ld, input logic [AW-1:0] din, input logic [2:0] o, input logic rd);
      @(negedge clk);
      ld_en = ld; bus_din = din; op = o; rd_en = rd;
      @(posedge clk);
      #1;
   endtask

   initial begin
      fork
         begin
            #1000000;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
         end
      join_none

      repeat (3) @(posedge clk);
      #1;
      check("R1 reset addr", addr, '0);
      check("R1 reset bus_dout", bus_dout, '0);
      check("R1 reset bus_oe", {17'd0, bus_oe}, 18'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][39], VEC[i][38:21], VEC[i][20:18], 1'b0);
         check($sformatf("R%0d vector %0d", VEC[i][43:40], i), addr, VEC[i][17:0]);
      end

      // R10: readback of pre-edge value while the counter steps
      step(1'b1, 18'h2ABCD, 3'd0, 1'b0);
      check("R8 load", addr, 18'h2ABCD);
      step(1'b0, '0, 3'd1, 1'b1);
      check("R10 readback value", bus_dout, 18'h2ABCD);
      check("R10 readback oe", {17'd0, bus_oe}, 18'd1);
      check("R2 inc during readback", addr, 18'h2ABCE);
      step(1'b0, '0, 3'd0, 1'b0);
      check("R10 bus released oe", {17'd0, bus_oe}, 18'd0);
      check("R10 bus released data", bus_dout, '0);

      // R1: reset in the middle of operation
      @(negedge clk);
      rst_n = 1'b0; rd_en = 1'b1; op = 3'd1;
      @(posedge clk);
      #1;
      check("R1 mid-run reset addr", addr, '0);
      check("R1 mid-run reset oe", {17'd0, bus_oe}, 18'd0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule